// File: doc/BRIEF.md
# Octal DAC serial command interface

This block is the digital front end of an eight-channel, 10-bit digital-to-analog converter. A host writes 16-bit command words over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block keeps one 10-bit code register per channel and presents all eight codes in parallel, together with a sleep flag for the analog section. Each word carries a 4-bit command and a 10-bit code. The command loads one channel, loads every channel with the same code, puts the converter to sleep, or does nothing. Any command other than sleep that is applied wakes the converter.

The serial pins are sampled by the block's system clock through synchronizers, and edges are detected on the synchronized levels. The serial link has no back-pressure, and the host alone sets the pace. Every level of the serial clock and the frame select must therefore be held for at least `SYNC_STAGES + 2` system clock cycles. A serial data output repeats the oldest bit of the shift register, so devices can be chained by wiring one device's output to the next device's input. An active-low clear zeroes every channel code and leaves sleep at once, without waiting for a clock edge. The power-on reset does the same and also empties the shift register.

Top module: `octal_dac_if`

## Requirements
- R1: Bits are taken MSB first on each rising serial clock edge while frame select is low. On the rising edge of frame select, the action is decoded from the last 16 bits received. Bits 15..12 hold the command, bits 11..2 hold the code and bits 1..0 are ignored. Frames shorter than 16 bits therefore reuse older bits.
- R2: Command values 1 through 8 load the code into channel 0 through 7 respectively. Channel k appears on `dac_codes[k*10 +: 10]`. No other channel changes.
- R3: Command 15 loads the same code into all eight channels.
- R4: Command 0 and commands 9 through 13 change no channel, and their code bits are discarded.
- R5: Command 14 raises `sleep_o` and leaves every channel code unchanged.
- R6: Applying any command other than 14 drops `sleep_o`. A no-update command used as a wake-up restores the outputs with the channel codes held before sleep.
- R7: While `clr_n` is low, every channel code is zero and `sleep_o` is low. Both take effect without a clock edge, and frames completed during the clear have no effect on the channels.
- R8: After `rst_n`, every channel code is zero, `sleep_o` is low and `sdo` is low.
- R9: On each falling serial clock edge while frame select is low, `sdo` takes the MSB of the 16-bit shift register. A bit entering `sdi` therefore leaves on `sdo` after 16 further clocks.
- R10: Serial clock edges while frame select is high neither shift data nor change `sdo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| clr_n | input | 1 | Active-low clear of all channel codes and of sleep, asynchronous |
| cs_n | input | 1 | Active-low frame select; its rising edge applies the command |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out for chaining |
| dac_codes | output | 80 | Eight 10-bit channel codes, channel k at bits k*10+9..k*10 |
| sleep_o | output | 1 | High while the converter is asleep |

## Verification
The bench builds the block with its defaults: eight channels, 10-bit codes, 16-bit frames and two synchronizer stages. With these values all sixteen command values can be reached. This includes the five values between the last channel and sleep that must behave as no-ops, and the boundary values 1, 8, 14 and 15. A 32-bit frame makes the 16-clock pass-through on the serial output visible within a single transfer. Short frames and clocks sent while the frame select is high show that only the last 16 selected bits decide the action.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_ALL   = {CMD_W{1'b1}};
  localparam logic [CMD_W-1:0] CMD_SLEEP = {{(CMD_W-1){1'b1}}, 1'b0};

  typedef enum logic [1:0] {
    ACT_NOP,
    ACT_ONE,
    ACT_ALL,
    ACT_SLEEP
  } act_e;

  // Map a command value to the action it requests, for a bank of nch channels.
  function automatic act_e decode_act(input logic [CMD_W-1:0] c, input int unsigned nch);
    if (c == CMD_ALL) return ACT_ALL;
    if (c == CMD_SLEEP) return ACT_SLEEP;
    if (c != '0 && 32'(c) <= nch) return ACT_ONE;
    return ACT_NOP;
  endfunction

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL[b]}};
      else        pipe <= {pipe[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe[STAGES-1];
  end

endmodule

// File: rtl/dacif_shifter.sv
module dacif_shifter #(
  parameter int FRAME_W = 16,
  parameter int OUT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             out_en,
  input  logic             sdi,
  output logic [OUT_W-1:0] word_o,
  output logic             sdo
);

  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else begin
      if (shift_en) sh <= {sh[FRAME_W-2:0], sdi};
      if (out_en)   sdo <= sh[FRAME_W-1];
    end
  end

  assign word_o = sh[FRAME_W-1 -: OUT_W];

  // The output pin moves only on a selected falling serial clock edge.
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> $stable(sdo)); // R10

endmodule

// File: rtl/dacif_cmd.sv
module dacif_cmd
  import dacif_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              load,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [NCH-1:0]    wr_en,
  output logic [CODE_W-1:0] wr_data,
  output logic              sleep_o
);

  act_e             act;
  logic [CMD_W-1:0] chan;

  assign act     = decode_act(cmd_i, NCH);
  assign chan    = cmd_i - 1'b1;
  assign wr_data = data_i;

  for (genvar i = 0; i < NCH; i++) begin : g_en
    assign wr_en[i] = load && ((act == ACT_ONE && chan == CMD_W'(i)) || act == ACT_ALL);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   sleep_o <= 1'b0;
    else if (load) sleep_o <= (act == ACT_SLEEP);
  end

  // Only a broadcast may write more than one channel in a cycle.
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    (cmd_i != CMD_ALL) |-> $onehot0(wr_en)); // R2

endmodule

// File: rtl/dacif_bank.sv
module dacif_bank #(
  parameter int NCH = 8,
  parameter int CODE_W = 10
) (
  input  logic                  clk,
  input  logic                  arst_n,
  input  logic [NCH-1:0]        wr_en,
  input  logic [CODE_W-1:0]     wr_data,
  output logic [NCH*CODE_W-1:0] codes_o
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CODE_W-1:0] q;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)       q <= '0;
      else if (wr_en[i]) q <= wr_data;
    end
    assign codes_o[i*CODE_W +: CODE_W] = q;
  end

endmodule

// File: rtl/octal_dac_if.sv
module octal_dac_if
  import dacif_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CODE_W = 10,
  parameter int FRAME_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_n,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic                  sdo,
  output logic [NCH*CODE_W-1:0] dac_codes,
  output logic                  sleep_o
);

  localparam int PAY_W = CMD_W + CODE_W;
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic             arst_n;
  logic [2:0]       pins_s;
  logic             sclk_s, sdi_s, cs_s;
  logic             sclk_d, cs_d;
  logic             sclk_rise, sclk_fall, cs_rise, selected;
  logic [PAY_W-1:0] word;
  logic [CMD_W-1:0] cmd;
  logic [CODE_W-1:0] data;
  logic [NCH-1:0]   wr_en;
  logic [CODE_W-1:0] wr_data;
  logic [CODE_W-1:0] code_arr [NCH];

  // Clear and power-on reset both empty the channel bank.
  assign arst_n = rst_n & clr_n;

  dacif_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_n, sdi, sclk}), .q_o(pins_s)
  );
  assign {cs_s, sdi_s, sclk_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign selected  = ~cs_s;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_rise   = cs_s & ~cs_d;

  dacif_shifter #(.FRAME_W(FRAME_W), .OUT_W(PAY_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(sclk_rise & selected), .out_en(sclk_fall & selected),
    .sdi(sdi_s), .word_o(word), .sdo(sdo)
  );

  assign cmd  = word[PAY_W-1 -: CMD_W];
  assign data = word[CODE_W-1:0];

  dacif_cmd #(.NCH(NCH), .CODE_W(CODE_W)) u_cmd (
    .clk(clk), .arst_n(arst_n), .load(cs_rise),
    .cmd_i(cmd), .data_i(data),
    .wr_en(wr_en), .wr_data(wr_data), .sleep_o(sleep_o)
  );

  dacif_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .wr_data(wr_data), .codes_o(dac_codes)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_view
    assign code_arr[i] = dac_codes[i*CODE_W +: CODE_W];
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!arst_n)
    cs_rise && cmd != '0 && 32'(cmd) <= NCH
    |=> code_arr[IDX_W'($past(cmd) - 1'b1)] == $past(data)); // R2

  AST_ALL_LOAD: assert property (@(posedge clk) disable iff (!arst_n)
    cs_rise && cmd == CMD_ALL
    |=> code_arr[0] == $past(data) && code_arr[NCH-1] == $past(data)); // R3

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    cs_rise && (cmd == '0 || (32'(cmd) > NCH && cmd < CMD_SLEEP))
    |=> $stable(dac_codes)); // R4

  AST_SLEEP_SET: assert property (@(posedge clk) disable iff (!arst_n)
    cs_rise && cmd == CMD_SLEEP |=> sleep_o && $stable(dac_codes)); // R5

  AST_WAKE: assert property (@(posedge clk) disable iff (!arst_n)
    cs_rise && cmd != CMD_SLEEP |=> !sleep_o); // R6

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_codes == '0 && !sleep_o); // R7

endmodule

// File: tb/tb_octal_dac_if.sv
`timescale 1ns/1ps
module tb_octal_dac_if;

  localparam int NCH = 8;
  localparam int CW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sleep_o;
  logic [NCH*CW-1:0] dac_codes;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [CW-1:0] m_code [NCH];
  logic          m_sleep;
  logic [15:0]   m_sh;

  always #10 clk = ~clk;

  octal_dac_if dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .dac_codes(dac_codes), .sleep_o(sleep_o)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Expected effect of an applied 16-bit word on the model.
  function automatic void model_apply(input logic [15:0] w);
    logic [3:0]    c = w[15:12];
    logic [CW-1:0] d = w[11:2];
    if (!clr_n) return;
    if (c >= 4'd1 && c <= 4'd8) m_code[c-1] = d;
    else if (c == 4'hF) for (int i = 0; i < NCH; i++) m_code[i] = d;
    m_sleep = (c == 4'hE);
  endfunction

  task automatic check_state(input string tag);
    for (int i = 0; i < NCH; i++)
      chk($sformatf("%s ch%0d", tag, i), 32'(dac_codes[i*CW +: CW]), 32'(m_code[i]));
    chk({tag, " sleep"}, 32'(sleep_o), 32'(m_sleep));
  endtask

  // Shift nb bits of w, MSB first, with frame select already low.
  task automatic shift_bits(input logic [31:0] w, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = w[i];
      wait_n(3);
      sclk = 1'b1;
      m_sh = {m_sh[14:0], w[i]};
      wait_n(5);
      sclk = 1'b0;
      wait_n(5);
      chk("R9 sdo", 32'(sdo), 32'(m_sh[15]));
    end
  endtask

  task automatic frame(input logic [31:0] w, input int nb, input string tag);
    cs_n = 1'b0;
    wait_n(3);
    shift_bits(w, nb);
    wait_n(2);
    cs_n = 1'b1;
    wait_n(6);
    model_apply(m_sh);
    check_state(tag);
  endtask

  // Serial clocks with frame select high: nothing may shift (R10).
  task automatic idle_clocks(input int n);
    logic prev_sdo;
    prev_sdo = sdo;
    for (int i = 0; i < n; i++) begin
      sdi = 1'($urandom);
      wait_n(4);
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
      wait_n(4);
    end
    chk("R10 sdo idle", 32'(sdo), 32'(prev_sdo));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < NCH; i++) m_code[i] = '0;
    m_sleep = 1'b0;
    m_sh = '0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    check_state("R8 reset");
    chk("R8 sdo", 32'(sdo), 32'd0);

    // R2: boundary channels, then every channel.
    frame({16'h0, 4'd1, 10'h2A5, 2'b11}, 16, "R2 ch0");
    frame({16'h0, 4'd8, 10'h3FF, 2'b00}, 16, "R2 ch7");
    for (int c = 1; c <= NCH; c++)
      frame({16'h0, 4'(c), 10'(c * 73), 2'b01}, 16, "R2 each");
    // R4: all no-update codes.
    frame({16'h0, 4'd0, 10'h155, 2'b00}, 16, "R4 code0");
    for (int c = 9; c <= 13; c++)
      frame({16'h0, 4'(c), 10'h0AA, 2'b10}, 16, "R4 code9-13");
    // R3 broadcast.
    frame({16'h0, 4'hF, 10'h1C3, 2'b00}, 16, "R3 all");
    // R5 sleep keeps codes; R6 no-update wake keeps them too.
    frame({16'h0, 4'hE, 10'h3FF, 2'b00}, 16, "R5 sleep");
    frame({16'h0, 4'd11, 10'h000, 2'b00}, 16, "R6 nop wake");
    frame({16'h0, 4'hE, 10'h000, 2'b00}, 16, "R5 sleep2");
    frame({16'h0, 4'd3, 10'h0F0, 2'b00}, 16, "R6 load wake");
    // R1: short frame reuses older bits of the register.
    frame({16'h0, 4'd2, 10'h3C3, 2'b00}, 16, "R1 full");
    frame({24'h0, 8'h5A}, 8, "R1 short");
    // R9: 32-bit transfer, the first word passes through to sdo.
    frame({4'd6, 10'h111, 2'b00, 4'd5, 10'h222, 2'b00}, 32, "R9 chain");
    // R10: clocks with frame select high, then a frame.
    idle_clocks(5);
    frame({16'h0, 4'd4, 10'h321, 2'b00}, 16, "R10 after idle");

    // R7: asynchronous clear mid-cycle, wakes from sleep.
    frame({16'h0, 4'hE, 10'h000, 2'b00}, 16, "R5 sleep3");
    @(negedge clk);
    #3 clr_n = 1'b0;
    #2;
    for (int i = 0; i < NCH; i++) m_code[i] = '0;
    m_sleep = 1'b0;
    check_state("R7 async clear");
    frame({16'h0, 4'hF, 10'h3AB, 2'b00}, 16, "R7 load during clear");
    @(negedge clk);
    clr_n = 1'b1;
    wait_n(2);
    check_state("R7 after release");

    // Random commands and codes.
    for (int k = 0; k < 50; k++) begin
      frame({16'h0, 4'($urandom_range(0, 15)), 10'($urandom), 2'($urandom)}, 16, "R1 random");
      if (k % 17 == 5) idle_clocks(2);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule